// File: doc/BRIEF.md
# Scan Conversion Sequencer with Bus Clock Stretching

This block runs the conversions of a multi-channel sampling converter that sits behind a two-wire serial bus and uses its own internal conversion clock. The bus front end supplies one-cycle strobes for the SCL rising and falling edges, a pulse at each START condition, and an address-match level. When a read address is accepted, the sequencer raises a tracking enable on the eighth SCL rising edge. It samples on the ninth SCL falling edge. It then holds SCL low while it runs one conversion after another, stepping through the channel codes up to a programmed scan limit, and it writes every result into the next entry of a result memory.

In single-ended mode each channel from 0 up to the limit is converted in turn. In differential mode the code steps by two. An even code selects an adjacent input pair with the lower-numbered input positive, and the odd code above it selects the same pair with the polarity swapped. The starting polarity comes from the lowest limit bit, and the scan stops at the pair the upper limit bits name. A limit that names no existing channel is a reserved setting: it starts nothing and SCL is not stretched. A watchdog counted in system clocks bounds each conversion. If the converter never reports done, the sequencer abandons the scan and releases SCL.

Top module: `scan_seq_stretch`

## Requirements
- R1: After reset, scl_hold, track_en, conv_start and mem_we are all low.
- R2: With cfg_ext_clk low and rd_addr_ok high, track_en goes high one cycle after the eighth scl_rise strobe that follows a bus_start pulse. With cfg_ext_clk high, or rd_addr_ok low, track_en stays low and no conversion starts.
- R3: One cycle after the ninth scl_fall strobe of an armed read, track_en is low, scl_hold is high and conv_start is high for exactly one cycle.
- R4: In single-ended mode (cfg_diff = 0) with limit L, the conversions use the codes 0, 1, ..., L in ascending order. conv_pos equals the code and conv_diff is low.
- R5: In differential mode (cfg_diff = 1) with limit L, the codes start at L[0] and rise by 2 up to the code whose bits [3:1] equal L[3:1]. conv_pos equals the code, conv_neg equals the code with bit 0 inverted, and conv_diff is high.
- R6: One cycle after conv_done, mem_we is high for exactly one cycle. mem_addr is the conversion's position in the scan, counting from 0, and mem_wdata is the conv_data value sampled with conv_done.
- R7: scl_hold stays high without a gap from the first conv_start to the last mem_we of the scan, and it falls in the cycle after the last mem_we.
- R8: A scan limit of NUM_CH (12) or more, in either mode, starts no conversion and never raises scl_hold.
- R9: If conv_done does not arrive within TMO_CYC cycles after conv_start, scl_hold falls after exactly TMO_CYC + 1 held cycles, nothing is written, and the scan ends.
- R10: Within a scan, each conv_start after the first comes in the cycle right after the previous mem_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse at a START or repeated START |
| scl_rise | input | 1 | One-cycle strobe at each SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe at each SCL falling edge |
| rd_addr_ok | input | 1 | Address byte matches and requests a read, valid at the eighth rise |
| cfg_ext_clk | input | 1 | 1 selects external conversion clock; 0 (reset value upstream) selects internal |
| cfg_scan_lim | input | CW (4) | Last channel code of the scan |
| cfg_diff | input | 1 | 1 selects differential pairs, 0 single-ended inputs |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_data | input | DW (12) | Converter result, valid with conv_done |
| scl_hold | output | 1 | Drive SCL low (stretch) |
| track_en | output | 1 | Input track phase in progress |
| conv_start | output | 1 | One-cycle start-of-conversion strobe |
| conv_pos | output | CW (4) | Positive input select |
| conv_neg | output | CW (4) | Negative input select (differential only) |
| conv_diff | output | 1 | Current conversion is differential |
| mem_we | output | 1 | Result memory write enable |
| mem_addr | output | AW (4) | Result memory write address |
| mem_wdata | output | DW (12) | Result memory write data |

## Verification
The bench drives inputs at falling clock edges and samples every output at the next falling edge. Track enable is checked at the first sample after the eighth rise strobe. Conversion start and SCL hold are checked at the first sample after the ninth fall strobe. A passive monitor records the cycle number of every conversion start and memory write, and of the first released-hold sample. The checks then compare those numbers: a write one sample after its conv_done, the next start one sample after a write, and the release one sample after the last write. The timeout case counts held samples and expects exactly TMO_CYC + 1.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_START = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_STORE = 2'd3
   } sq_state_e;
endpackage

// File: rtl/scl_phase_tracker.sv
module scl_phase_tracker #(
   parameter int TRACK_RISE   = 8,
   parameter int SAMPLE_FALLS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_start,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic addr_ok,
   input  logic ext_clk,
   output logic track_en,
   output logic sample_go
);
   localparam int RW = $clog2(TRACK_RISE + 2);
   localparam int FW = $clog2(SAMPLE_FALLS + 1);
   localparam logic [RW-1:0] RISE_ARM = RW'(TRACK_RISE - 1);
   localparam logic [RW-1:0] RISE_SAT = RW'(TRACK_RISE + 1);
   localparam logic [FW-1:0] FALL_LAST = FW'(SAMPLE_FALLS - 1);

   generate
      if (TRACK_RISE < 1) begin : g_bad_rise
         $error("TRACK_RISE must be at least 1");
      end
      if (SAMPLE_FALLS < 1) begin : g_bad_fall
         $error("SAMPLE_FALLS must be at least 1");
      end
   endgenerate

   logic [RW-1:0] rise_cnt;
   logic [FW-1:0] fall_cnt;
   logic          armed;

   assign sample_go = armed & scl_fall & (fall_cnt == FALL_LAST);
   assign track_en  = armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         fall_cnt <= '0;
         armed    <= 1'b0;
      end else if (bus_start) begin
         rise_cnt <= '0;
         fall_cnt <= '0;
         armed    <= 1'b0;
      end else begin
         if (scl_rise && rise_cnt != RISE_SAT)
            rise_cnt <= rise_cnt + 1'b1;
         if (scl_rise && rise_cnt == RISE_ARM && addr_ok && !ext_clk) begin
            armed    <= 1'b1;
            fall_cnt <= '0;
         end else if (armed && scl_fall) begin
            if (fall_cnt == FALL_LAST)
               armed <= 1'b0;
            fall_cnt <= fall_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/chan_stepper.sv
module chan_stepper #(
   parameter int NUM_CH       = 12,
   parameter bit SUPPORT_DIFF = 1'b1,
   parameter int CW           = 4,
   parameter int AW           = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [CW-1:0] lim,
   input  logic          diff,
   output logic          cfg_ok,
   output logic          last,
   output logic [CW-1:0] pos,
   output logic [CW-1:0] neg,
   output logic          diff_q,
   output logic [AW-1:0] idx
);
   localparam logic [CW:0] CH_LIM = (CW+1)'(NUM_CH);

   logic [CW-1:0] code;
   logic [CW-1:0] lim_q;
   logic          diff_sel;
   logic          diff_r;

   assign cfg_ok = ({1'b0, lim} < CH_LIM);

   generate
      if (SUPPORT_DIFF) begin : g_diff
         if (NUM_CH % 2 != 0) begin : g_odd
            $error("Differential pairs need an even channel count");
         end
         assign diff_sel = diff;
         assign diff_q   = diff_r;
         assign neg      = diff_r ? {code[CW-1:1], ~code[0]} : '0;
         assign last     = diff_r ? (code[CW-1:1] == lim_q[CW-1:1])
                                  : (code == lim_q);
      end else begin : g_single
         assign diff_sel = 1'b0;
         assign diff_q   = 1'b0;
         assign neg      = '0;
         assign last     = (code == lim_q);
      end
   endgenerate

   assign pos = code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= '0;
         lim_q  <= '0;
         diff_r <= 1'b0;
         idx    <= '0;
      end else if (load) begin
         code   <= diff_sel ? {{(CW-1){1'b0}}, lim[0]} : '0;
         lim_q  <= lim;
         diff_r <= diff_sel;
         idx    <= '0;
      end else if (adv) begin
         code   <= code + (diff_r ? CW'(2) : CW'(1));
         idx    <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/conv_watchdog.sv
module conv_watchdog #(
   parameter int TMO_CYC = 830
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired
);
   generate
      if (TMO_CYC == 0) begin : g_off
         assign expired = 1'b0;
      end else begin : g_on
         localparam int TW = $clog2(TMO_CYC + 1);
         localparam logic [TW-1:0] CNT_END = TW'(TMO_CYC - 1);
         logic [TW-1:0] cnt;
         assign expired = run & (cnt == CNT_END);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (start)
               cnt <= '0;
            else if (run && !expired)
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/scan_seq_stretch.sv
module scan_seq_stretch #(
   parameter int NUM_CH       = 12,
   parameter int DW           = 12,
   parameter int TMO_CYC      = 830,
   parameter bit SUPPORT_DIFF = 1'b1,
   parameter int CW           = 4,
   parameter int AW           = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_start,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          rd_addr_ok,
   input  logic          cfg_ext_clk,
   input  logic [CW-1:0] cfg_scan_lim,
   input  logic          cfg_diff,
   input  logic          conv_done,
   input  logic [DW-1:0] conv_data,
   output logic          scl_hold,
   output logic          track_en,
   output logic          conv_start,
   output logic [CW-1:0] conv_pos,
   output logic [CW-1:0] conv_neg,
   output logic          conv_diff,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   import scanseq_pkg::*;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CW)) begin : g_bad_cw
         $error("CW too narrow for NUM_CH");
      end
      if (NUM_CH > (1 << AW)) begin : g_bad_aw
         $error("AW too narrow for NUM_CH");
      end
   endgenerate

   sq_state_e st, st_nx;
   logic      sample_go;
   logic      cfg_ok;
   logic      last;
   logic      wd_expired;
   logic      load, adv;
   logic [DW-1:0] data_q;

   scl_phase_tracker #(.TRACK_RISE(8), .SAMPLE_FALLS(2)) phase_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_start (bus_start),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .addr_ok   (rd_addr_ok),
      .ext_clk   (cfg_ext_clk),
      .track_en  (track_en),
      .sample_go (sample_go)
   );

   assign load = (st == SQ_IDLE) && sample_go && cfg_ok;
   assign adv  = (st == SQ_STORE);

   chan_stepper #(
      .NUM_CH(NUM_CH), .SUPPORT_DIFF(SUPPORT_DIFF), .CW(CW), .AW(AW)
   ) step_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .adv    (adv),
      .lim    (cfg_scan_lim),
      .diff   (cfg_diff),
      .cfg_ok (cfg_ok),
      .last   (last),
      .pos    (conv_pos),
      .neg    (conv_neg),
      .diff_q (conv_diff),
      .idx    (mem_addr)
   );

   conv_watchdog #(.TMO_CYC(TMO_CYC)) wd_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (st == SQ_START),
      .run     (st == SQ_WAIT),
      .expired (wd_expired)
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         SQ_IDLE:  if (load) st_nx = SQ_START;
         SQ_START: st_nx = SQ_WAIT;
         SQ_WAIT: begin
            if (conv_done)       st_nx = SQ_STORE;
            else if (wd_expired) st_nx = SQ_IDLE;
         end
         SQ_STORE: st_nx = last ? SQ_IDLE : SQ_START;
         default:  st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         data_q <= '0;
      end else begin
         st <= st_nx;
         if (st == SQ_WAIT && conv_done)
            data_q <= conv_data;
      end
   end

   assign scl_hold   = (st != SQ_IDLE);
   assign conv_start = (st == SQ_START);
   assign mem_we     = (st == SQ_STORE);
   assign mem_wdata  = data_q;
endmodule

// File: rtl/scan_seq_stretch_props.sv
module scan_seq_stretch_props #(
   parameter int NUM_CH  = 12,
   parameter int TMO_CYC = 830,
   parameter int CW      = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_hold,
   input logic          track_en,
   input logic          conv_start,
   input logic          mem_we,
   input logic [CW-1:0] conv_pos,
   input logic          tmo_hit
);
   int unsigned hold_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_run <= 0;
      else if (conv_start) hold_run <= 1;
      else if (scl_hold)   hold_run <= hold_run + 1;
      else                 hold_run <= 0;
   end

   // R3
   start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> scl_hold && !track_en);

   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R6
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R7
   we_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> scl_hold);

   // R7
   release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_hold) |-> ($past(mem_we) || $past(tmo_hit)));

   // R2
   track_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({track_en, scl_hold}));

   // R4
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (int'(conv_pos) < NUM_CH));

   // R9
   hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (TMO_CYC > 0 && scl_hold) |-> (hold_run <= TMO_CYC + 1));
endmodule

bind scan_seq_stretch scan_seq_stretch_props #(
   .NUM_CH(NUM_CH), .TMO_CYC(TMO_CYC), .CW(CW)
) props_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_hold   (scl_hold),
   .track_en   (track_en),
   .conv_start (conv_start),
   .mem_we     (mem_we),
   .conv_pos   (conv_pos),
   .tmo_hit    (wd_expired)
);

// File: tb/scan_seq_stretch_tb_top.sv
module scan_seq_stretch_tb_top;
   localparam int CLK_PER = 10;
   localparam int TMO     = 64;
   localparam int DLY     = 5;
   localparam int NCH     = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_start = 0, scl_rise = 0, scl_fall = 0, rd_addr_ok = 0;
   logic        cfg_ext_clk = 0, cfg_diff = 0;
   logic [3:0]  cfg_scan_lim = 0;
   logic        conv_done = 0;
   logic [11:0] conv_data = 0;
   logic        scl_hold, track_en, conv_start, conv_diff, mem_we;
   logic [3:0]  conv_pos, conv_neg, mem_addr;
   logic [11:0] mem_wdata;

   int checks = 0, errors = 0;
   int cyc = 0;

   always #(CLK_PER/2) clk = ~clk;

   scan_seq_stretch #(.NUM_CH(NCH), .DW(12), .TMO_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .rd_addr_ok(rd_addr_ok), .cfg_ext_clk(cfg_ext_clk),
      .cfg_scan_lim(cfg_scan_lim), .cfg_diff(cfg_diff), .conv_done(conv_done),
      .conv_data(conv_data), .scl_hold(scl_hold), .track_en(track_en),
      .conv_start(conv_start), .conv_pos(conv_pos), .conv_neg(conv_neg),
      .conv_diff(conv_diff), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata)
   );

   // converter stub and monitor, both at the falling edge
   logic stub_en = 1'b1;
   int   pend = 0, stub_k = 0;
   int   n_st = 0, n_we = 0, n_held = 0, rel_cyc = -1, done_cyc = 0;
   int   st_cyc[16], st_pos[16], st_neg[16], st_dif[16];
   int   we_cyc[16], we_addr[16], we_data[16], dn_cyc[16];
   bit   seen = 0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      conv_done <= 1'b0;
      if (conv_start && stub_en) pend <= DLY;
      else if (pend > 0) begin
         pend <= pend - 1;
         if (pend == 1) begin
            conv_done <= 1'b1;
            conv_data <= 12'(12'h300 + stub_k * 37 + int'(conv_pos));
            if (stub_k < 16) dn_cyc[stub_k] <= cyc;
            stub_k <= stub_k + 1;
         end
      end
      if (scl_hold) n_held <= n_held + 1;
      if (conv_start && n_st < 16) begin
         st_cyc[n_st] <= cyc; st_pos[n_st] <= int'(conv_pos);
         st_neg[n_st] <= int'(conv_neg); st_dif[n_st] <= int'(conv_diff);
         n_st <= n_st + 1; seen <= 1'b1;
      end
      if (mem_we && n_we < 16) begin
         we_cyc[n_we] <= cyc; we_addr[n_we] <= int'(mem_addr);
         we_data[n_we] <= int'(mem_wdata);
         n_we <= n_we + 1;
      end
      if (seen && !scl_hold && rel_cyc < 0) rel_cyc <= cyc;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      @(negedge clk);
      n_st = 0; n_we = 0; n_held = 0; rel_cyc = -1; seen = 0; stub_k = 0;
   endtask

   task automatic strobe(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
      @(negedge clk);
   endtask

   // drives START, 8 address clocks and the 9th clock; checks R2/R3 timing
   task automatic do_read(input bit addr_ok, input bit ext, input bit expect_go);
      cfg_ext_clk = ext;
      rd_addr_ok  = addr_ok;
      strobe(bus_start);
      for (int i = 1; i <= 9; i++) begin
         @(negedge clk); scl_rise = 1'b1;
         @(negedge clk); scl_rise = 1'b0;
         if (i == 8) chk(track_en == (addr_ok && !ext), "R2 track after 8th rise",
                         int'(track_en), int'(addr_ok && !ext));
         @(negedge clk); scl_fall = 1'b1;
         @(negedge clk); scl_fall = 1'b0;
         if (i == 9) begin
            chk(!track_en, "R3 track low after 9th fall", int'(track_en), 0);
            chk(conv_start == expect_go, "R3 conv_start after 9th fall",
                int'(conv_start), int'(expect_go));
            chk(scl_hold == expect_go, "R3/R8 hold after 9th fall",
                int'(scl_hold), int'(expect_go));
         end
         @(negedge clk);
      end
      for (int w = 0; w < 2000 && scl_hold; w++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_scan(input int lim, input bit dif);
      int n = dif ? (lim / 2) + 1 : lim + 1;
      int ok_codes = 1, ok_data = 1, ok_b2b = 1, ok_wtime = 1;
      chk(n_st == n, dif ? "R5 conversion count" : "R4 conversion count", n_st, n);
      chk(n_we == n, "R6 write count", n_we, n);
      for (int k = 0; k < n && k < n_st && k < n_we; k++) begin
         int code = dif ? (lim % 2) + 2 * k : k;
         int en = dif ? (code ^ 1) : 0;
         if (st_pos[k] != code || (dif && st_neg[k] != en) || st_dif[k] != int'(dif)) begin
            ok_codes = 0;
            $display("FAIL %s: actual pos %0d neg %0d expected pos %0d neg %0d",
                     dif ? "R5" : "R4", st_pos[k], st_neg[k], code, en);
         end
         if (we_addr[k] != k || we_data[k] != 12'h300 + k * 37 + code) begin
            ok_data = 0;
            $display("FAIL R6: addr %0d data %0h expected addr %0d data %0h",
                     we_addr[k], we_data[k], k, 12'h300 + k * 37 + code);
         end
         if (we_cyc[k] != dn_cyc[k] + 1) ok_wtime = 0;
         if (k > 0 && st_cyc[k] != we_cyc[k-1] + 1) ok_b2b = 0;
      end
      chk(ok_codes == 1, dif ? "R5 pair sequence" : "R4 channel sequence", ok_codes, 1);
      chk(ok_data == 1, "R6 memory address and data", ok_data, 1);
      chk(ok_wtime == 1, "R6 write one cycle after done", ok_wtime, 1);
      chk(ok_b2b == 1, "R10 back-to-back starts", ok_b2b, 1);
      if (n_we > 0) begin
         chk(rel_cyc == we_cyc[n_we-1] + 1, "R7 release after last write",
             rel_cyc, we_cyc[n_we-1] + 1);
         chk(n_held == rel_cyc - st_cyc[0], "R7 hold without gap",
             n_held, rel_cyc - st_cyc[0]);
      end
   endtask

   task automatic t_reset();
      chk(!scl_hold && !track_en && !conv_start && !mem_we, "R1 reset outputs",
          int'({scl_hold, track_en, conv_start, mem_we}), 0);
   endtask

   task automatic t_single(input int lim);
      clr_mon(); cfg_diff = 0; cfg_scan_lim = 4'(lim);
      do_read(1, 0, 1);
      check_scan(lim, 0);
   endtask

   task automatic t_diff(input int lim);
      clr_mon(); cfg_diff = 1; cfg_scan_lim = 4'(lim);
      do_read(1, 0, 1);
      check_scan(lim, 1);
   endtask

   task automatic t_no_go(input bit addr_ok, input bit ext, input int lim,
                          input bit dif, input string req);
      clr_mon(); cfg_diff = dif; cfg_scan_lim = 4'(lim);
      do_read(addr_ok, ext, 0);
      chk(n_st == 0, req, n_st, 0);
      chk(n_held == 0, req, n_held, 0);
   endtask

   task automatic t_timeout();
      clr_mon(); stub_en = 0; cfg_diff = 0; cfg_scan_lim = 4'd3;
      do_read(1, 0, 1);
      chk(n_held == TMO + 1, "R9 held cycles on timeout", n_held, TMO + 1);
      chk(n_we == 0, "R9 no write on timeout", n_we, 0);
      chk(n_st == 1, "R9 scan abandoned", n_st, 1);
      stub_en = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(0);
      t_single(5);
      t_single(11);
      t_diff(0);
      t_diff(7);
      t_diff(10);
      t_diff(11);
      t_no_go(0, 0, 3, 0, "R2 no address match");
      t_no_go(1, 1, 3, 0, "R2 external clock mode");
      t_no_go(1, 0, 12, 0, "R8 limit beyond channels");
      t_no_go(1, 0, 13, 1, "R8 reserved differential code");
      t_no_go(1, 0, 15, 1, "R8 reserved differential code");
      t_timeout();
      t_single(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule